// File: doc/BRIEF.md
# PIO Data Port Engine with Block Interrupts

This block runs the 16-bit programmed-I/O data register of a packet-command storage device. It moves words between the host data port and a byte-addressed buffer that sits outside the block. A read transfer is armed with a total byte length and a block size. The engine then presents buffer words to the host one at a time. It pulses an interrupt each time a whole block has been consumed, and again when the whole transfer has been consumed.

A write transfer is armed with a byte length. Host words are stored into the buffer until that length has been covered. The engine then reports to the command parser how many bytes were written.

The engine drives the data-request flag and the interrupt event that the task-file registers take in. It also exposes the armed read byte count split into a low byte and a high byte, matching the two cylinder-count registers of the task file. Buffer words are little-endian: the low byte of a word sits at the even buffer address, and the high byte sits at the address after it.

Top module: `pio_data_port`

## Requirements
- R1: A read start with a nonzero length sets drq_o from the next cycle on and shows the length on cnt_lo_o (bits 7:0) and cnt_hi_o (bits 15:8). A write start leaves the count unchanged.
- R2: While a read is active, buf_addr_o starts at 0 and advances by 2 per host read. host_rd_data_o equals buf_rdata_i, which carries the byte at buf_addr_o in bits 7:0 and the byte at buf_addr_o+1 in bits 15:8.
- R3: When a read leaves length still remaining but uses up the block-left count (block-left at or below zero), irq_o pulses for one cycle after that read, and block-left is reloaded with the block size.
- R4: The read that uses up the remaining length ends the transfer. drq_o falls and irq_o pulses one cycle after it. Only one pulse is given, even when a block boundary falls on the same read.
- R5: With no read active, host_rd_data_o is 0xFFFF, and a host read changes no output.
- R6: During an active write, each host write drives buf_we_o with buf_wdata_o equal to the host word and buf_addr_o equal to the byte offset, starting at 0 and stepping by 2. Host writes with no write active raise no buf_we_o and change no state.
- R7: The write that covers the armed length ends the transfer. One cycle later drq_o is low and wr_done_o pulses for one cycle, with wr_count_o equal to the number of bytes written.
- R8: An odd byte length is rounded up to a whole final word, for reads and writes alike. A 5-byte write takes 3 words and reports 6.
- R9: A start of either direction cancels a transfer in progress and restarts the offset at 0. A host access in the start cycle is ignored. When both starts are given together, the read start wins.
- R10: After reset, and after a start with length 0, no transfer is active: drq_o, irq_o and wr_done_o are low, and the count is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_start_i | input | 1 | Arm a read transfer |
| rd_len_i | input | LEN_W | Read length in bytes |
| blk_size_i | input | LEN_W | Read block size in bytes |
| wr_start_i | input | 1 | Arm a write transfer |
| wr_len_i | input | LEN_W | Write length in bytes |
| host_rd_i | input | 1 | Host data-port read strobe |
| host_rd_data_o | output | 16 | Word returned to host |
| host_wr_i | input | 1 | Host data-port write strobe |
| host_wr_data_i | input | 16 | Word written by host |
| buf_addr_o | output | LEN_W | Buffer byte offset of current word |
| buf_rdata_i | input | 16 | Buffer word at buf_addr_o |
| buf_we_o | output | 1 | Buffer word write enable |
| buf_wdata_o | output | 16 | Buffer write word |
| drq_o | output | 1 | Data request (transfer active) |
| cnt_lo_o | output | 8 | Read byte count, low byte |
| cnt_hi_o | output | 8 | Read byte count, high byte |
| irq_o | output | 1 | One-cycle interrupt event |
| wr_done_o | output | 1 | One-cycle write-complete event |
| wr_count_o | output | LEN_W+1 | Bytes written in finished transfer |

## Verification
The hardest cases to reach are the ones where the final read and a block boundary fall on the same word. The same goes for block sizes of one word and block sizes equal to the length, because each of these cases leaves one fewer interrupt than a naive count predicts.

The stimulus drives reads back to back and also with gaps, using block sizes of 2 and 4 bytes and a block size equal to the length. It also uses a long read whose count needs the high byte. Cancellation is reached by issuing a start of the opposite direction partway through a transfer, and by issuing both starts in the same cycle. A behavioural model compares every output on every clock.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int WORD_W = 16;
  typedef enum logic [1:0] {
    XFER_IDLE = 2'd0,
    XFER_RD   = 2'd1,
    XFER_WR   = 2'd2
  } xfer_e;
endpackage

// File: rtl/pio_len_track.sv
module pio_len_track #(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] blk_i,
  input  logic             step_i,
  output logic             last_o,
  output logic             blk_hit_o
);
  localparam int CW = LEN_W + 2;
  localparam logic signed [CW-1:0] STEP = CW'(2);

  logic signed [CW-1:0] rem_q, blk_q;
  logic [LEN_W-1:0]     bs_q;

  // remaining value after this word would be <= 0
  assign last_o    = (rem_q <= STEP);
  assign blk_hit_o = (blk_q <= STEP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      blk_q <= '0;
      bs_q  <= '0;
    end else if (load_i) begin
      rem_q <= signed'({2'b00, len_i});
      blk_q <= signed'({2'b00, blk_i});
      bs_q  <= blk_i;
    end else if (step_i) begin
      rem_q <= rem_q - STEP;
      blk_q <= blk_hit_o ? signed'({2'b00, bs_q}) : blk_q - STEP;
    end
  end
endmodule

// File: rtl/pio_addr_gen.sv
module pio_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W:0]   addr_nxt_o
);
  logic [ADDR_W-1:0] addr_q;

  assign addr_o     = addr_q;
  assign addr_nxt_o = {1'b0, addr_q} + (ADDR_W+1)'(2);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_nxt_o[ADDR_W-1:0];
  end
endmodule

// File: rtl/pio_data_port.sv
module pio_data_port
  import pio_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               rd_start_i,
  input  logic [LEN_W-1:0]   rd_len_i,
  input  logic [LEN_W-1:0]   blk_size_i,
  input  logic               wr_start_i,
  input  logic [LEN_W-1:0]   wr_len_i,
  input  logic               host_rd_i,
  output logic [WORD_W-1:0]  host_rd_data_o,
  input  logic               host_wr_i,
  input  logic [WORD_W-1:0]  host_wr_data_i,
  output logic [LEN_W-1:0]   buf_addr_o,
  input  logic [WORD_W-1:0]  buf_rdata_i,
  output logic               buf_we_o,
  output logic [WORD_W-1:0]  buf_wdata_o,
  output logic               drq_o,
  output logic [7:0]         cnt_lo_o,
  output logic [7:0]         cnt_hi_o,
  output logic               irq_o,
  output logic               wr_done_o,
  output logic [LEN_W:0]     wr_count_o
);
  xfer_e            mode_q;
  logic             start_any, rd_go, wr_go, step;
  logic             last, blk_hit;
  logic [LEN_W-1:0] load_len;
  logic [LEN_W:0]   addr_nxt;
  logic [15:0]      cnt_q;
  logic             irq_q, done_q;
  logic [LEN_W:0]   wcnt_q;

  assign start_any = rd_start_i | wr_start_i;
  assign load_len  = rd_start_i ? rd_len_i : wr_len_i;
  // a start takes the cycle; host access in it is dropped
  assign rd_go     = host_rd_i & (mode_q == XFER_RD) & ~start_any;
  assign wr_go     = host_wr_i & (mode_q == XFER_WR) & ~start_any;
  assign step      = rd_go | wr_go;

  pio_len_track #(.LEN_W(LEN_W)) u_len (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (start_any),
    .len_i     (load_len),
    .blk_i     (blk_size_i),
    .step_i    (step),
    .last_o    (last),
    .blk_hit_o (blk_hit)
  );

  pio_addr_gen #(.ADDR_W(LEN_W)) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_any),
    .inc_i      (step),
    .addr_o     (buf_addr_o),
    .addr_nxt_o (addr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= XFER_IDLE;
      cnt_q  <= '0;
      irq_q  <= 1'b0;
      done_q <= 1'b0;
      wcnt_q <= '0;
    end else begin
      irq_q  <= rd_go & (last | blk_hit);
      done_q <= wr_go & last;
      if (rd_start_i) begin
        mode_q <= (rd_len_i != '0) ? XFER_RD : XFER_IDLE;
        cnt_q  <= 16'(rd_len_i);
      end else if (wr_start_i) begin
        mode_q <= (wr_len_i != '0) ? XFER_WR : XFER_IDLE;
      end else if (step && last) begin
        mode_q <= XFER_IDLE;
      end
      if (wr_go && last) wcnt_q <= addr_nxt;
    end
  end

  assign host_rd_data_o = (mode_q == XFER_RD) ? buf_rdata_i : '1;
  assign buf_we_o       = wr_go;
  assign buf_wdata_o    = host_wr_data_i;
  assign drq_o          = (mode_q != XFER_IDLE);
  assign cnt_lo_o       = cnt_q[7:0];
  assign cnt_hi_o       = cnt_q[15:8];
  assign irq_o          = irq_q;
  assign wr_done_o      = done_q;
  assign wr_count_o     = wcnt_q;
endmodule

// File: rtl/pio_data_port_chk.sv
module pio_data_port_chk #(
  parameter int LEN_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rd_start_i,
  input logic [LEN_W-1:0] rd_len_i,
  input logic             wr_start_i,
  input logic             host_rd_i,
  input logic [15:0]      host_rd_data_o,
  input logic             buf_we_o,
  input logic             drq_o,
  input logic [7:0]       cnt_lo_o,
  input logic [7:0]       cnt_hi_o,
  input logic             irq_o,
  input logic             wr_done_o
);
  // R1
  drq_on_rd_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i && rd_len_i != '0) |=> drq_o);
  // R1
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_start_i |=> ({cnt_hi_o, cnt_lo_o} == 16'($past(rd_len_i))));
  // R5
  idle_rd_ffff_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drq_o |-> (host_rd_data_o == 16'hFFFF));
  // R6
  idle_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drq_o |-> !buf_we_o);
  // R3
  irq_after_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(host_rd_i));
  // R7
  done_drq_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |-> !drq_o);
  // R7
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_done_o |=> !wr_done_o);
  // R9
  start_no_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i || wr_start_i) |-> !buf_we_o);
endmodule

bind pio_data_port pio_data_port_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .rd_start_i     (rd_start_i),
  .rd_len_i       (rd_len_i),
  .wr_start_i     (wr_start_i),
  .host_rd_i      (host_rd_i),
  .host_rd_data_o (host_rd_data_o),
  .buf_we_o       (buf_we_o),
  .drq_o          (drq_o),
  .cnt_lo_o       (cnt_lo_o),
  .cnt_hi_o       (cnt_hi_o),
  .irq_o          (irq_o),
  .wr_done_o      (wr_done_o)
);

// File: tb/pio_data_port_bench.sv
module pio_data_port_bench;
  localparam int LEN_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_start = 0, wr_start = 0, host_rd = 0, host_wr = 0;
  logic [LEN_W-1:0] rd_len = '0, blk_size = '0, wr_len = '0;
  logic [15:0] host_wr_data = '0, host_rd_data, buf_rdata, buf_wdata;
  logic [LEN_W-1:0] buf_addr;
  logic buf_we, drq, irq, wr_done;
  logic [7:0] cnt_lo, cnt_hi;
  logic [LEN_W:0] wr_count;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  function automatic logic [7:0] bytev(input int a);
    return 8'((a * 7 + 3) & 255);
  endfunction

  // little-endian buffer image (R2)
  assign buf_rdata = {bytev(int'(buf_addr) + 1), bytev(int'(buf_addr))};

  pio_data_port #(.LEN_W(LEN_W)) u_pio_data_port (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_start_i(rd_start), .rd_len_i(rd_len), .blk_size_i(blk_size),
    .wr_start_i(wr_start), .wr_len_i(wr_len),
    .host_rd_i(host_rd), .host_rd_data_o(host_rd_data),
    .host_wr_i(host_wr), .host_wr_data_i(host_wr_data),
    .buf_addr_o(buf_addr), .buf_rdata_i(buf_rdata),
    .buf_we_o(buf_we), .buf_wdata_o(buf_wdata),
    .drq_o(drq), .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi),
    .irq_o(irq), .wr_done_o(wr_done), .wr_count_o(wr_count)
  );

  // behavioural model: 0 idle, 1 read, 2 write
  int m_mode, m_rem, m_blk, m_bs, m_ptr, m_cnt, m_wcnt;
  bit m_irq, m_done;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_blk = 0; m_bs = 0; m_ptr = 0;
      m_cnt = 0; m_wcnt = 0; m_irq = 0; m_done = 0;
    end else begin
      m_irq = 0; m_done = 0;
      if (rd_start) begin
        m_mode = (rd_len != 0) ? 1 : 0;
        m_rem = rd_len; m_blk = blk_size; m_bs = blk_size; m_ptr = 0; m_cnt = rd_len;
      end else if (wr_start) begin
        m_mode = (wr_len != 0) ? 2 : 0;
        m_rem = wr_len; m_ptr = 0;
      end else if (host_rd && m_mode == 1) begin
        m_ptr += 2; m_rem -= 2; m_blk -= 2;
        if (m_rem <= 0) begin m_mode = 0; m_irq = 1; end
        else if (m_blk <= 0) begin m_irq = 1; m_blk = m_bs; end
      end else if (host_wr && m_mode == 2) begin
        m_ptr += 2; m_rem -= 2;
        if (m_rem <= 0) begin m_mode = 0; m_done = 1; m_wcnt = m_ptr; end
      end
    end
  end

  task automatic cmp(input string what, input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // compare just before each rising edge
  always begin
    @(negedge clk); #4;
    if (rst_n && !finished) begin
      bit we_e;
      we_e = host_wr && m_mode == 2 && !rd_start && !wr_start;
      cmp("drq", "R1", drq, m_mode != 0);
      cmp("count", "R1", {cnt_hi, cnt_lo}, m_cnt);
      cmp("irq", "R3/R4", irq, m_irq);
      cmp("wr_done", "R7", wr_done, m_done);
      if (m_done) cmp("wr_count", "R7", wr_count, m_wcnt);
      cmp("rd_data", m_mode == 1 ? "R2" : "R5", host_rd_data,
          m_mode == 1 ? {bytev(m_ptr + 1), bytev(m_ptr)} : 16'hFFFF);
      if (m_mode != 0) cmp("buf_addr", "R2", buf_addr, m_ptr & 16'hFFFF);
      cmp("buf_we", "R6", buf_we, we_e);
      if (we_e) cmp("buf_wdata", "R6", buf_wdata, host_wr_data);
    end
  end

  task automatic step(input bit rs, input bit ws, input bit hr, input bit hw,
                      input int rl = 0, input int bl = 0, input int wl = 0,
                      input logic [15:0] wd = 16'h0);
    @(negedge clk); #1;
    rd_start = rs; wr_start = ws; host_rd = hr; host_wr = hw;
    rd_len = LEN_W'(rl); blk_size = LEN_W'(bl); wr_len = LEN_W'(wl);
    host_wr_data = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic reads(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 1, 0);
      if (gap) idle(1 + (i % 3));
    end
    idle(2);
  endtask

  task automatic writes(input int n, input bit gap);
    for (int i = 0; i < n; i++) begin
      step(0, 0, 0, 1, 0, 0, 0, 16'(16'hA500 + i * 16'h0103));
      if (gap) idle(1);
    end
    idle(2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    idle(2);                                   // R10 reset state
    reads(2, 0);                               // R5 reads while idle
    writes(2, 0);                              // R6 writes while idle ignored
    step(1, 0, 0, 0, 12, 4); reads(6, 0);      // R3 block irqs, R4 end
    step(1, 0, 0, 0, 12, 4); reads(6, 1);      // R2 gaps between reads
    step(1, 0, 0, 0, 7, 64); reads(5, 0);      // R8 odd read length
    step(1, 0, 0, 0, 8, 2); reads(4, 0);       // R3 irq every word
    step(1, 0, 0, 0, 10, 10); reads(5, 0);     // R4 boundary on last word
    step(1, 0, 0, 0, 300, 256); reads(151, 0); // R1 high count byte
    step(0, 1, 0, 0, 0, 0, 12); writes(7, 0);  // R6 R7 write
    step(0, 1, 0, 0, 0, 0, 5); writes(3, 1);   // R8 odd write rounds up
    // R9 cancel read by write start
    step(1, 0, 0, 0, 16, 4); reads(3, 0);
    step(0, 1, 0, 0, 0, 0, 4); writes(3, 0);
    // R9 cancel write by read start, then host access during start cycle
    step(0, 1, 0, 0, 0, 0, 20); writes(2, 0);
    step(1, 0, 0, 1, 6, 4); reads(4, 0);
    // R9 simultaneous starts, read wins
    step(1, 1, 1, 1, 4, 2, 8); reads(3, 0);
    // R10 zero-length starts leave engine idle
    step(1, 0, 0, 0, 0, 4); reads(1, 0);
    step(0, 1, 0, 0, 0, 0, 0); writes(1, 0);
    idle(3);
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule